// File: doc/BRIEF.md
# Exponent-Ranked Pivot Row Selector

This block chooses the pivot row for each step of a division-free Gauss-Jordan elimination. Every row processing element presents the value it holds in the current pivot column. The selector ranks the candidates by exponent field alone. It runs them through a registered binary tree of two-input comparators and reports which row won, together with that row's full floating-point word as the multiplier for the step.

A sticky eligibility vector keeps the order of pivots consistent across steps. A row that has been chosen is taken out of later contests, so no row data ever needs to be physically exchanged: the winning element simply acts as master for the step. A solve-clear control makes every row eligible again before a new system is loaded. Selections are fully pipelined, and a new request may enter on every cycle. A flag warns when no usable, non-zero candidate was left.

Top module: `pivot_select`

## Requirements
- R1: After synchronous reset, `done` is low and every row is eligible.
- R2: Each cycle with `start` high yields exactly one `done` pulse, exactly LEVELS = ceil(log2(NROWS)) cycles later. Requests may be issued on consecutive cycles.
- R3: Among eligible rows, the one whose exponent field (bits 30..23 of the 32-bit word) is largest wins. The sign bit (31) and the mantissa (22..0) have no effect on the ranking.
- R4: When eligible rows tie on exponent, the lowest row index wins.
- R5: A row whose eligibility bit is clear never wins against an eligible row, and an eligibility bit is never set again except by `solve_clr`.
- R6: On the clock edge at which `done` is high, the bit of the reported row is cleared. A request issued before that edge is ranked with the older mask.
- R7: `solve_clr` makes all rows eligible from the next cycle on. A `start` in the same cycle as `solve_clr` is already ranked with every row eligible.
- R8: When `solve_clr` and `done` are high in the same cycle, the clear wins and the reported row stays eligible.
- R9: `singular` is high with `done` when the winning exponent is zero. The index is then the lowest eligible row, or row 0 if no row is eligible.
- R10: `pivot_val` is the complete, unchanged 32-bit word of the reported row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| solve_clr | input | 1 | Make all rows eligible (start of a new solve) |
| start | input | 1 | Request one pivot selection from the current row values |
| row_vals | input | NROWS*32 | Pivot-column word of each row, row r at bits 32r+31..32r |
| done | output | 1 | Result of a request is valid this cycle |
| pivot_idx | output | ceil(log2(NROWS)) | Index of the selected row |
| pivot_val | output | 32 | Word of the selected row |
| singular | output | 1 | Selected exponent is zero |

## Verification
Two functions can land on the same clock edge and pull the mask in opposite directions. One is the clearing of the winner's bit when `done` is high; the other is the global reset of the mask by `solve_clr`. The bench issues a request, then drives `solve_clr` exactly in the cycle its `done` appears. It judges the outcome by sending another request over equal exponents, which must again return the row that had just been reported. A second collision, `start` together with `solve_clr`, is judged by the request seeing rows that had been retired.

// File: rtl/pvt_pkg.sv
// Shared format constants, candidate type and ranking rule for the
// pivot selector. Assumes 32-bit words: sign, 8-bit exponent, 23-bit mantissa.
package pvt_pkg;
    localparam int FP_EXP_W = 8;
    localparam int FP_MAN_W = 23;
    localparam int FP_W     = 1 + FP_EXP_W + FP_MAN_W;

    typedef struct packed {
        logic [FP_EXP_W-1:0] mag;   // ranking exponent, zero when masked
        logic                live;  // row was eligible at request time
        logic [FP_W-1:0]     word;  // original word, carried to the output
    } cand_t;

    // Lower-index side wins unless the other side ranks strictly higher.
    function automatic logic lo_side_wins(cand_t lo, cand_t hi);
        return {lo.mag, lo.live} >= {hi.mag, hi.live};
    endfunction
endpackage

// File: rtl/pvt_leaf.sv
// Forms the tree leaves: slices each row word, applies the eligibility
// mask (masked rows rank with exponent zero) and pads to a power of two.
// Assumes PAD >= NROWS.
module pvt_leaf
    import pvt_pkg::*;
#(
    parameter int NROWS = 8,
    parameter int PAD   = 8
) (
    input  logic [NROWS*FP_W-1:0] row_vals,
    input  logic [NROWS-1:0]      mask,
    output cand_t                 leaves [PAD]
);
    for (genvar p = 0; p < PAD; p++) begin : g_leaf
        if (p < NROWS) begin : g_real
            logic [FP_W-1:0] w;
            // slice the row word
            assign w = row_vals[p*FP_W +: FP_W];
            // masked rows lose their exponent and live bit
            assign leaves[p] = '{mag:  mask[p] ? w[FP_W-2 -: FP_EXP_W] : '0,
                                 live: mask[p],
                                 word: w};
        end else begin : g_pad
            // pad slots rank below every real row
            assign leaves[p] = '0;
        end
    end
endmodule

// File: rtl/pvt_node.sv
// One registered comparator of the tree. Keeps the lower-index input on a
// tie so the overall selection prefers lower rows.
module pvt_node
    import pvt_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cand_t            lo_c,
    input  cand_t            hi_c,
    input  logic [IDX_W-1:0] lo_i,
    input  logic [IDX_W-1:0] hi_i,
    output cand_t            win_c,
    output logic [IDX_W-1:0] win_i
);
    // register the better of the two candidates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_c <= '0;
            win_i <= '0;
        end else if (lo_side_wins(lo_c, hi_c)) begin
            win_c <= lo_c;
            win_i <= lo_i;
        end else begin
            win_c <= hi_c;
            win_i <= hi_i;
        end
    end
endmodule

// File: rtl/pvt_elig.sv
// Sticky eligibility vector. A reported winner is retired; solve_clr
// restores every row and overrides retirement in the same cycle.
module pvt_elig #(
    parameter int NROWS = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             solve_clr,
    input  logic             retire,
    input  logic [IDX_W-1:0] retire_idx,
    output logic [NROWS-1:0] elig,
    output logic [NROWS-1:0] mask
);
    // mask seen by a request: a same-cycle clear already counts
    assign mask = solve_clr ? '1 : elig;

    // update the stored eligibility
    always_ff @(posedge clk) begin
        if (!rst_n || solve_clr) begin
            elig <= '1;
        end else if (retire && (32'(retire_idx) < NROWS)) begin
            elig[retire_idx] <= 1'b0;
        end
    end
endmodule

// File: rtl/pivot_select.sv
// Pivot row selector: registered binary comparator tree over exponent
// fields with a sticky eligibility mask. Assumes NROWS >= 2.
module pivot_select
    import pvt_pkg::*;
#(
    parameter int NROWS = 8,
    localparam int LEVELS = $clog2(NROWS),
    localparam int IDX_W  = LEVELS,
    localparam int PAD    = 1 << LEVELS,
    localparam int NODES  = 2 * PAD - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  solve_clr,
    input  logic                  start,
    input  logic [NROWS*FP_W-1:0] row_vals,
    output logic                  done,
    output logic [IDX_W-1:0]      pivot_idx,
    output logic [FP_W-1:0]       pivot_val,
    output logic                  singular
);
    logic [NROWS-1:0]  elig_q;
    logic [NROWS-1:0]  mask;
    logic [LEVELS-1:0] vld_q;
    cand_t             leaves [PAD];
    cand_t             heap   [NODES];
    logic [IDX_W-1:0]  hidx   [NODES];

    pvt_elig #(.NROWS(NROWS), .IDX_W(IDX_W)) u_elig (
        .clk(clk), .rst_n(rst_n), .solve_clr(solve_clr),
        .retire(done), .retire_idx(pivot_idx),
        .elig(elig_q), .mask(mask)
    );

    pvt_leaf #(.NROWS(NROWS), .PAD(PAD)) u_leaf (
        .row_vals(row_vals), .mask(mask), .leaves(leaves)
    );

    // leaves occupy the last PAD slots of the heap
    for (genvar p = 0; p < PAD; p++) begin : g_leafmap
        assign heap[PAD-1+p] = leaves[p];
        assign hidx[PAD-1+p] = IDX_W'(p);
    end

    // internal nodes: node n compares children 2n+1 (lower rows) and 2n+2
    for (genvar n = 0; n < PAD - 1; n++) begin : g_node
        pvt_node #(.IDX_W(IDX_W)) u_node (
            .clk(clk), .rst_n(rst_n),
            .lo_c(heap[2*n+1]), .hi_c(heap[2*n+2]),
            .lo_i(hidx[2*n+1]), .hi_i(hidx[2*n+2]),
            .win_c(heap[n]), .win_i(hidx[n])
        );
    end

    // request tracker walks alongside the tree levels
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= (vld_q << 1) | LEVELS'(start);
    end

    assign done      = vld_q[LEVELS-1];
    assign pivot_idx = hidx[0];
    assign pivot_val = heap[0].word;
    assign singular  = !heap[0].live || (heap[0].mag == '0);
endmodule

// File: rtl/pivot_select_chk.sv
// Protocol checker for pivot_select, attached by bind below.
module pivot_select_chk
    import pvt_pkg::*;
#(
    parameter int NROWS = 8,
    localparam int LEVELS = $clog2(NROWS),
    localparam int IDX_W  = LEVELS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             solve_clr,
    input logic             start,
    input logic             done,
    input logic [IDX_W-1:0] pivot_idx,
    input logic [FP_W-1:0]  pivot_val,
    input logic             singular,
    input logic [NROWS-1:0] elig
);
    logic [LEVELS-1:0] req_sh;

    // independent record of recent requests
    always_ff @(posedge clk) begin
        if (!rst_n) req_sh <= '0;
        else        req_sh <= (req_sh << 1) | LEVELS'(start);
    end

    AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        done == req_sh[LEVELS-1]);                                        // R2
    AST_NO_REVIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !solve_clr |=> (elig & ~$past(elig)) == '0);                      // R5
    AST_WINNER_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !solve_clr) |=> !elig[$past(pivot_idx)]);                // R6
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        solve_clr |=> (elig == '1));                                      // R7
    AST_CLEAR_BEATS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (solve_clr && done) |=> elig[$past(pivot_idx)]);                  // R8
    AST_NONZERO_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !singular) |-> (pivot_val[FP_W-2 -: FP_EXP_W] != '0));   // R9
endmodule

bind pivot_select pivot_select_chk #(.NROWS(NROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .solve_clr(solve_clr), .start(start),
    .done(done), .pivot_idx(pivot_idx), .pivot_val(pivot_val),
    .singular(singular), .elig(elig_q)
);

// File: tb/pivot_select_test.sv
// Bench for pivot_select: behavioural cycle model compared every cycle,
// plus directed scenarios per requirement.
module pivot_select_test;
    import pvt_pkg::*;
    localparam int N = 8;
    localparam int L = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic solve_clr = 1'b0;
    logic start = 1'b0;
    logic [N*FP_W-1:0] row_vals;
    logic done;
    logic [L-1:0] pivot_idx;
    logic [FP_W-1:0] pivot_val;
    logic singular;

    logic [FP_W-1:0] rows [N];
    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    // pack bench rows onto the input bus
    always_comb begin
        for (int r = 0; r < N; r++) row_vals[r*FP_W +: FP_W] = rows[r];
    end

    pivot_select #(.NROWS(N)) uut (
        .clk(clk), .rst_n(rst_n), .solve_clr(solve_clr), .start(start),
        .row_vals(row_vals), .done(done), .pivot_idx(pivot_idx),
        .pivot_val(pivot_val), .singular(singular)
    );

    // reference model state
    logic [N-1:0] m_elig = '1;
    bit m_v [L];
    int m_i [L];
    logic [FP_W-1:0] m_w [L];
    bit m_s [L];
    initial for (int i = 0; i < L; i++) begin
        m_v[i] = 0; m_i[i] = 0; m_w[i] = '0; m_s[i] = 0;
    end

    function automatic int expo(logic [FP_W-1:0] w);
        return int'(w[30:23]);
    endfunction

    // behavioural reference model, advanced on each edge
    always @(posedge clk) begin
        bit ov; int oi; logic [N-1:0] msk; int best; int bexp;
        if (!rst_n) begin
            m_elig = '1;
            for (int i = 0; i < L; i++) m_v[i] = 0;
        end else begin
            ov = m_v[L-1]; oi = m_i[L-1];
            msk = solve_clr ? '1 : m_elig;
            for (int i = L - 1; i > 0; i--) begin
                m_v[i] = m_v[i-1]; m_i[i] = m_i[i-1];
                m_w[i] = m_w[i-1]; m_s[i] = m_s[i-1];
            end
            best = -1; bexp = 0;
            for (int r = 0; r < N; r++)
                if (msk[r] && (best < 0 || expo(rows[r]) > bexp)) begin
                    best = r; bexp = expo(rows[r]);
                end
            m_v[0] = start;
            m_s[0] = (best < 0) || (bexp == 0);
            m_i[0] = (best < 0) ? 0 : best;
            m_w[0] = rows[m_i[0]];
            if (solve_clr) m_elig = '1;
            else if (ov) m_elig[oi] = 1'b0;
        end
    end

    // compare outputs against the model away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (done !== m_v[L-1]) begin
                fails++;
                $display("FAIL %s: done=%0b expected %0b", cur_req, done, m_v[L-1]);
            end
            if (m_v[L-1]) begin
                checks++;
                if (int'(pivot_idx) != m_i[L-1] || pivot_val !== m_w[L-1] ||
                    singular !== m_s[L-1]) begin
                    fails++;
                    $display("FAIL %s: idx=%0d val=%h sing=%0b expected idx=%0d val=%h sing=%0b",
                             cur_req, pivot_idx, pivot_val, singular,
                             m_i[L-1], m_w[L-1], m_s[L-1]);
                end
            end
        end
    end

    task automatic step(input bit st, input bit cl);
        start = st; solve_clr = cl;
        @(negedge clk);
    endtask

    // one request, then wait until its retirement has taken effect
    task automatic pick();
        step(1, 0);
        repeat (L) step(0, 0);
    endtask

    task automatic set_row(input int r, input bit s, input int e, input int m);
        rows[r] = {s, 8'(e), 23'(m)};
    endtask

    task automatic all_rows(input int e);
        for (int r = 0; r < N; r++) set_row(r, r[0], e, 1000 * (N - r));
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

    initial begin
        all_rows(100);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset leaves done low and all rows eligible
        cur_req = "R1";
        checks++;
        if (done !== 1'b0) begin
            fails++;
            $display("FAIL R1: done=%0b expected 0", done);
        end
        pick();                           // equal exponents, all eligible -> row 0

        // R3 / R10: sign and mantissa ignored, full word returned
        cur_req = "R3";
        step(0, 1);
        set_row(0, 0, 10, 5);
        set_row(1, 0, 50, 0);
        set_row(2, 0, 49, 23'h7FFFFF);
        set_row(3, 1, 120, 3);
        set_row(4, 0, 119, 23'h7FFFFF);
        set_row(5, 1, 1, 9);
        set_row(6, 0, 118, 0);
        set_row(7, 1, 117, 77);
        pick();                           // row 3 (negative, biggest exponent)
        cur_req = "R10";
        pick();                           // row 4
        // R6: retired winners give way to the next best
        cur_req = "R6";
        pick();                           // row 6
        pick();                           // row 7

        // R4: equal exponents resolved toward lower index
        cur_req = "R4";
        step(0, 1);
        all_rows(7);
        set_row(5, 1, 9, 1);
        set_row(6, 0, 9, 23'h7FFFFF);
        pick();                           // row 5
        pick();                           // row 6
        // R5: retired rows lose to eligible ones
        cur_req = "R5";
        pick();                           // row 0
        pick();                           // row 1

        // R2: back-to-back requests, all ranked with the old mask
        cur_req = "R2";
        step(0, 1);
        step(1, 0);
        step(1, 0);
        step(1, 0);
        step(1, 0);
        repeat (L) step(0, 0);
        pick();                           // row 5 retired -> row 6

        // R7: start with solve_clr sees every row
        cur_req = "R7";
        step(1, 1);                       // row 5 again despite retirement
        repeat (L) step(0, 0);

        // R8: clear lands in the same cycle as done
        cur_req = "R8";
        step(0, 1);
        all_rows(40);
        step(1, 0);
        repeat (L - 1) step(0, 0);
        step(0, 1);                       // done high now together with clear
        pick();                           // row 0 must win again

        // R9: zero exponents and exhausted mask
        cur_req = "R9";
        step(0, 1);
        all_rows(0);
        set_row(0, 0, 200, 1);
        set_row(1, 0, 210, 1);
        set_row(2, 0, 220, 1);
        repeat (3) pick();                // rows 2, 1, 0 retired
        pick();                           // eligible all zero -> singular, row 3
        for (int k = 0; k < 4; k++) pick();
        pick();                           // none eligible -> singular, row 0
        repeat (3) step(0, 0);
        summary();
    end
endmodule